// File: doc/BRIEF.md
# Windowed Translation Request Coalescer

This block sits in front of an address translation unit and cuts the number of lookups it must serve. Each incoming request carries a virtual address, a read/write mode, a prefetch flag, a requester tag and a merged-request count. Requests are gathered into groups, and one group stands for every request that targets the same virtual page with the same mode within one arrival window. A window is a fixed run of `WIN_LEN` clock cycles. Each group holds its member tags in arrival order and the sum of the members' counts. Prefetch members add no count.

Every cycle the block offers up to `PROBES` groups on parallel downstream lanes, each lane with valid/ready. Only groups of the oldest window that still holds groups are offered. Groups are taken in slot-index order, and a group whose page already has a translation in flight is passed over. A taken group frees its slot and its page is entered into an outstanding table. The page leaves that table when the completion input names it. The page walk and the fan-out of results back to the members are outside this block.

Top module: `xlat_coalescer`

## Requirements
- R1: Two requests merge only if they were accepted in the same window. The window index of a request is its accept cycle (counted from the end of reset) divided by `WIN_LEN`.
- R2: Two requests merge only if `vaddr >> PAGE_SHIFT` is equal for both. That value is the page number presented on the lane's `dn_page` field.
- R3: Two requests merge only if their modes are equal, with `req_write`=1 meaning write. The lane's `dn_write` bit shows the group's mode.
- R4: While `coalesce_off` is 1, every accepted request forms a group of its own.
- R5: At most `PROBES` groups are offered per cycle. Lanes are filled from lane 0 upward with no gaps, and candidates are taken in slot-index order. Slots are allocated lowest-free-index first.
- R6: A group whose page is in the outstanding table is not offered, and a later group of the same window may be offered past it. Two groups with the same page are never offered in one cycle. A `done_valid` pulse removes its page from the table at that clock edge.
- R7: No group of a later window is offered while any group of an older window remains, even when every older group is blocked.
- R8: Lane k is taken at a clock edge only if lanes 0 to k are all valid and ready. A group that is not taken stays stored and is offered again in a later cycle.
- R9: A group's count starts at the leader's `req_cnt`, or 0 if the leader is a prefetch. Each non-prefetch joiner adds its `req_cnt`, and the sum saturates at all ones. `dn_members` is the member total. Lane k's tag j sits at `dn_tags[(k*MAXM+j)*ID_W +: ID_W]` in arrival order, with j=0 being the leader.
- R10: `req_ready` is 0 exactly when all `NSLOT` slots hold groups.
- R11: A group holds at most `MAXM` members. A request joins the first matching slot in index order that has room. If no such slot exists, it starts a new group.
- R12: After reset, `req_ready` is 1 and no lane is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coalesce_off | input | 1 | Forces one group per request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | A free group slot exists |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_prefetch | input | 1 | Request is a prefetch |
| req_id | input | ID_W | Requester tag |
| req_cnt | input | CNT_W | Requests this one already stands for |
| dn_valid | output | PROBES | Lane offers a group |
| dn_ready | input | PROBES | Downstream takes the lane |
| dn_page | output | PROBES*PAGE_W | Page number per lane |
| dn_write | output | PROBES | Mode per lane |
| dn_count | output | PROBES*CNT_W | Merged count per lane |
| dn_members | output | PROBES*MEM_W | Member total per lane |
| dn_tags | output | PROBES*MAXM*ID_W | Member tags per lane |
| done_valid | input | 1 | A translation finished |
| done_page | input | PAGE_W | Page of the finished translation |

## Verification
A request accepted at a clock edge is visible in its group on the lanes from that edge onward, so its effect is due one cycle after it is driven. A lane taken at an edge vanishes from the lanes, and the next candidate appears, from that same edge. A completion frees its page at its edge, and a blocked group shows up on the lanes immediately after that edge. The bench drives every input on the falling edge and samples on the following falling edge. It also counts rising edges since reset, so it can place requests on either side of a window boundary at will.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/xlc_win_timer.sv
module xlc_win_timer #(
  parameter int WIN_LEN = 8,
  parameter int WIN_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIN_W-1:0] win_id
);
  localparam int PH_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      win_id <= '0;
    end else if (phase == PH_W'(WIN_LEN - 1)) begin
      phase  <= '0;
      win_id <= win_id + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/xlc_out_table.sv
module xlc_out_table #(
  parameter int NOUT   = 4,
  parameter int PAGE_W = 20,
  parameter int PROBES = 2,
  localparam int FC_W  = $clog2(NOUT + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PROBES-1:0]        ins_v,
  input  logic [PROBES*PAGE_W-1:0] ins_page,
  input  logic                     done_v,
  input  logic [PAGE_W-1:0]        done_page,
  output logic [NOUT-1:0]          ent_v,
  output logic [NOUT*PAGE_W-1:0]   ent_page,
  output logic [FC_W-1:0]          free_cnt
);
  logic [NOUT-1:0]   put;
  logic [PAGE_W-1:0] put_pg [NOUT];

  // lane k lands in the k-th free entry
  always_comb begin
    int k;
    k = 0;
    free_cnt = '0;
    for (int e = 0; e < NOUT; e++) begin
      put[e]    = 1'b0;
      put_pg[e] = '0;
      if (!ent_v[e]) begin
        free_cnt = free_cnt + 1'b1;
        if (k < PROBES) begin
          if (ins_v[k]) begin
            put[e]    = 1'b1;
            put_pg[e] = ins_page[k*PAGE_W +: PAGE_W];
          end
        end
        k++;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
    end else begin
      for (int e = 0; e < NOUT; e++) begin
        if (done_v && ent_v[e] && ent_page[e*PAGE_W +: PAGE_W] == done_page)
          ent_v[e] <= 1'b0;
        if (put[e]) begin
          ent_v[e] <= 1'b1;
          ent_page[e*PAGE_W +: PAGE_W] <= put_pg[e];
        end
      end
    end
  end

  generate
    for (genvar k = 0; k < PROBES; k++) begin : g_room
      // R6: every issued page finds a free entry
      a_r6_ins_room: assert property (@(posedge clk) disable iff (rst)
        ins_v[k] |-> (int'(free_cnt) > k));
    end
  endgenerate
endmodule

// File: rtl/xlc_issue_sel.sv
module xlc_issue_sel #(
  parameter int NSLOT  = 8,
  parameter int NOUT   = 4,
  parameter int PROBES = 2,
  parameter int PAGE_W = 20,
  parameter int WIN_W  = 8,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int FC_W   = $clog2(NOUT + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSLOT-1:0]         slot_v,
  input  logic [NSLOT*WIN_W-1:0]   slot_win,
  input  logic [NSLOT*PAGE_W-1:0]  slot_page,
  input  logic [WIN_W-1:0]         cur_win,
  input  logic [NOUT-1:0]          ot_v,
  input  logic [NOUT*PAGE_W-1:0]   ot_page,
  input  logic [FC_W-1:0]          free_cnt,
  output logic [PROBES-1:0]        lane_v,
  output logic [PROBES*SLOT_W-1:0] lane_slot
);
  logic [WIN_W-1:0]  oldest;
  logic [PAGE_W-1:0] lpage [PROBES];

  always_comb begin
    logic [WIN_W-1:0] best_age;
    logic [WIN_W-1:0] age;
    logic             have;
    logic             cand;
    logic [PAGE_W-1:0] pg;
    int avail;
    int n;
    best_age = '0;
    have     = 1'b0;
    oldest   = cur_win;
    for (int s = 0; s < NSLOT; s++) begin
      age = cur_win - slot_win[s*WIN_W +: WIN_W];
      if (slot_v[s] && (!have || age > best_age)) begin
        have     = 1'b1;
        best_age = age;
        oldest   = slot_win[s*WIN_W +: WIN_W];
      end
    end
    avail = (int'(free_cnt) < PROBES) ? int'(free_cnt) : PROBES;
    n = 0;
    lane_v    = '0;
    lane_slot = '0;
    for (int k = 0; k < PROBES; k++) lpage[k] = '0;
    for (int s = 0; s < NSLOT; s++) begin
      pg   = slot_page[s*PAGE_W +: PAGE_W];
      cand = slot_v[s] && (slot_win[s*WIN_W +: WIN_W] == oldest);
      for (int e = 0; e < NOUT; e++)
        if (ot_v[e] && ot_page[e*PAGE_W +: PAGE_W] == pg) cand = 1'b0;
      for (int k = 0; k < PROBES; k++)
        if (k < n && lpage[k] == pg) cand = 1'b0;
      if (cand && n < avail) begin
        lane_v[n] = 1'b1;
        lane_slot[n*SLOT_W +: SLOT_W] = SLOT_W'(s);
        lpage[n] = pg;
        n++;
      end
    end
  end

  generate
    for (genvar k = 1; k < PROBES; k++) begin : g_pack
      // R5: lanes fill from lane 0 without gaps
      a_r5_lanes_packed: assert property (@(posedge clk) disable iff (rst)
        lane_v[k] |-> lane_v[k-1]);
    end
  endgenerate
endmodule

// File: rtl/xlat_coalescer.sv
module xlat_coalescer
  import xlc_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ID_W       = 4,
  parameter int CNT_W      = 6,
  parameter int NSLOT      = 8,
  parameter int MAXM       = 4,
  parameter int NOUT       = 4,
  parameter int PROBES     = 2,
  parameter int WIN_LEN    = 8,
  parameter int WIN_W      = 8,
  localparam int PAGE_W    = VA_W - PAGE_SHIFT,
  localparam int MEM_W     = $clog2(MAXM + 1),
  localparam int SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int FC_W      = $clog2(NOUT + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          coalesce_off,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [VA_W-1:0]               req_vaddr,
  input  logic                          req_write,
  input  logic                          req_prefetch,
  input  logic [ID_W-1:0]               req_id,
  input  logic [CNT_W-1:0]              req_cnt,
  output logic [PROBES-1:0]             dn_valid,
  input  logic [PROBES-1:0]             dn_ready,
  output logic [PROBES*PAGE_W-1:0]      dn_page,
  output logic [PROBES-1:0]             dn_write,
  output logic [PROBES*CNT_W-1:0]       dn_count,
  output logic [PROBES*MEM_W-1:0]       dn_members,
  output logic [PROBES*MAXM*ID_W-1:0]   dn_tags,
  input  logic                          done_valid,
  input  logic [PAGE_W-1:0]             done_page
);
  // group slot storage
  logic [NSLOT-1:0]  s_v;
  logic [WIN_W-1:0]  s_win   [NSLOT];
  logic [PAGE_W-1:0] s_page  [NSLOT];
  acc_mode_e         s_mode  [NSLOT];
  logic [CNT_W-1:0]  s_cnt   [NSLOT];
  logic [MEM_W-1:0]  s_nmem  [NSLOT];
  logic [ID_W-1:0]   s_tag   [NSLOT][MAXM];

  logic [WIN_W-1:0]  cur_win;
  logic [NOUT-1:0]   ot_v;
  logic [NOUT*PAGE_W-1:0] ot_page;
  logic [FC_W-1:0]   ot_free;
  logic [PROBES-1:0] lane_v;
  logic [PROBES*SLOT_W-1:0] lane_slot;
  logic [PROBES-1:0] lane_take;
  logic [NSLOT*WIN_W-1:0]  f_win;
  logic [NSLOT*PAGE_W-1:0] f_page;
  logic [NSLOT-1:0]  gone;

  logic [PAGE_W-1:0] r_page;
  acc_mode_e         r_mode;
  logic              unused_ofs;
  logic              hit, have_free, acc_req;
  logic [SLOT_W-1:0] hit_idx, free_idx;
  logic [CNT_W-1:0]  add_cnt;
  logic [CNT_W:0]    sum_cnt;

  assign r_page     = req_vaddr[VA_W-1:PAGE_SHIFT];
  assign r_mode     = req_write ? MODE_WR : MODE_RD;
  assign unused_ofs = ^req_vaddr[PAGE_SHIFT-1:0];
  assign req_ready  = ~&s_v;
  assign acc_req    = req_valid && req_ready;
  assign add_cnt    = req_prefetch ? '0 : req_cnt;

  xlc_win_timer #(.WIN_LEN(WIN_LEN), .WIN_W(WIN_W)) u_timer (
    .clk(clk), .rst(rst), .win_id(cur_win));

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      f_win[s*WIN_W +: WIN_W]    = s_win[s];
      f_page[s*PAGE_W +: PAGE_W] = s_page[s];
    end
  end

  xlc_issue_sel #(
    .NSLOT(NSLOT), .NOUT(NOUT), .PROBES(PROBES),
    .PAGE_W(PAGE_W), .WIN_W(WIN_W)
  ) u_sel (
    .clk(clk), .rst(rst), .slot_v(s_v), .slot_win(f_win),
    .slot_page(f_page), .cur_win(cur_win), .ot_v(ot_v),
    .ot_page(ot_page), .free_cnt(ot_free),
    .lane_v(lane_v), .lane_slot(lane_slot));

  // a lane is taken only if every lane below it is taken too
  always_comb begin
    logic chain;
    chain = 1'b1;
    gone  = '0;
    for (int k = 0; k < PROBES; k++) begin
      chain = chain && lane_v[k] && dn_ready[k];
      lane_take[k] = chain;
      if (chain) gone[lane_slot[k*SLOT_W +: SLOT_W]] = 1'b1;
    end
  end

  xlc_out_table #(.NOUT(NOUT), .PAGE_W(PAGE_W), .PROBES(PROBES)) u_ot (
    .clk(clk), .rst(rst), .ins_v(lane_take), .ins_page(dn_page),
    .done_v(done_valid), .done_page(done_page),
    .ent_v(ot_v), .ent_page(ot_page), .free_cnt(ot_free));

  assign dn_valid = lane_v;

  generate
    for (genvar k = 0; k < PROBES; k++) begin : g_lane
      logic [SLOT_W-1:0] sl;
      assign sl = lane_slot[k*SLOT_W +: SLOT_W];
      assign dn_page[k*PAGE_W +: PAGE_W]   = s_page[sl];
      assign dn_write[k]                   = (s_mode[sl] == MODE_WR);
      assign dn_count[k*CNT_W +: CNT_W]    = s_cnt[sl];
      assign dn_members[k*MEM_W +: MEM_W]  = s_nmem[sl];
      for (genvar j = 0; j < MAXM; j++) begin : g_tag
        assign dn_tags[(k*MAXM+j)*ID_W +: ID_W] = s_tag[sl][j];
      end
      // R6: an offered page is never already outstanding
      for (genvar e = 0; e < NOUT; e++) begin : g_pend
        a_r6_not_pending: assert property (@(posedge clk) disable iff (rst)
          dn_valid[k] |-> !(ot_v[e] && ot_page[e*PAGE_W +: PAGE_W] ==
                            dn_page[k*PAGE_W +: PAGE_W]));
      end
    end
  endgenerate

  // first matching slot in index order, else lowest free slot
  always_comb begin
    hit       = 1'b0;
    hit_idx   = '0;
    have_free = 1'b0;
    free_idx  = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (!hit && s_v[s] && !gone[s] && !coalesce_off &&
          s_win[s] == cur_win && s_page[s] == r_page &&
          s_mode[s] == r_mode && s_nmem[s] < MEM_W'(MAXM)) begin
        hit     = 1'b1;
        hit_idx = SLOT_W'(s);
      end
      if (!have_free && !s_v[s]) begin
        have_free = 1'b1;
        free_idx  = SLOT_W'(s);
      end
    end
    sum_cnt = {1'b0, s_cnt[hit_idx]} + {1'b0, add_cnt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_v <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++)
        if (gone[s]) s_v[s] <= 1'b0;
      if (acc_req) begin
        if (hit) begin
          s_cnt[hit_idx] <= sum_cnt[CNT_W] ? '1 : sum_cnt[CNT_W-1:0];
          s_tag[hit_idx][s_nmem[hit_idx]] <= req_id;
          s_nmem[hit_idx] <= s_nmem[hit_idx] + 1'b1;
        end else if (have_free) begin
          s_v[free_idx]      <= 1'b1;
          s_win[free_idx]    <= cur_win;
          s_page[free_idx]   <= r_page;
          s_mode[free_idx]   <= r_mode;
          s_cnt[free_idx]    <= add_cnt;
          s_nmem[free_idx]   <= MEM_W'(1);
          s_tag[free_idx][0] <= req_id;
        end
      end
    end
  end

  // R10: an accepted request always has a home
  a_r10_accept_lands: assert property (@(posedge clk) disable iff (rst)
    acc_req |-> (hit || have_free));

  // R8: a refused lane 0 is offered again next cycle
  a_r8_refused_stays: assert property (@(posedge clk) disable iff (rst)
    (dn_valid[0] && !dn_ready[0]) |=> dn_valid[0]);

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_cap
      // R11: member total stays within 1..MAXM
      a_r11_members_cap: assert property (@(posedge clk) disable iff (rst)
        s_v[s] |-> (s_nmem[s] >= MEM_W'(1) && s_nmem[s] <= MEM_W'(MAXM)));
    end
  endgenerate
endmodule

// File: tb/xlat_coalescer_tb.sv
module xlat_coalescer_tb;
  localparam int CLK_NS = 10;
  localparam int WL = 8;
  localparam int NS = 8;
  localparam int MM = 4;
  localparam int PR = 2;
  localparam int CW = 6;
  localparam int MW = 3;
  localparam int IW = 4;
  localparam int PW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coalesce_off = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_vaddr = '0;
  logic req_write = 1'b0;
  logic req_prefetch = 1'b0;
  logic [IW-1:0] req_id = '0;
  logic [CW-1:0] req_cnt = '0;
  logic [PR-1:0] dn_valid;
  logic [PR-1:0] dn_ready = '0;
  logic [PR*PW-1:0] dn_page;
  logic [PR-1:0] dn_write;
  logic [PR*CW-1:0] dn_count;
  logic [PR*MW-1:0] dn_members;
  logic [PR*MM*IW-1:0] dn_tags;
  logic done_valid = 1'b0;
  logic [PW-1:0] done_page = '0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  xlat_coalescer u_dut (
    .clk(clk), .rst(rst), .coalesce_off(coalesce_off),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_prefetch(req_prefetch), .req_id(req_id),
    .req_cnt(req_cnt), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_page(dn_page), .dn_write(dn_write), .dn_count(dn_count),
    .dn_members(dn_members), .dn_tags(dn_tags),
    .done_valid(done_valid), .done_page(done_page));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [PW-1:0] lpg(input int k);
    return dn_page[k*PW +: PW];
  endfunction
  function automatic logic [CW-1:0] lcnt(input int k);
    return dn_count[k*CW +: CW];
  endfunction
  function automatic logic [MW-1:0] lmem(input int k);
    return dn_members[k*MW +: MW];
  endfunction
  function automatic logic [IW-1:0] ltag(input int k, input int j);
    return dn_tags[(k*MM+j)*IW +: IW];
  endfunction

  task automatic send(input logic [PW-1:0] pg, input bit wr, input bit pf,
                      input logic [IW-1:0] id, input logic [CW-1:0] cnt);
    req_valid = 1'b1;
    req_vaddr = {pg, 8'h3C, id};
    req_write = wr;
    req_prefetch = pf;
    req_id = id;
    req_cnt = cnt;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic take(input logic [PR-1:0] m);
    dn_ready = m;
    @(negedge clk);
    dn_ready = '0;
  endtask

  task automatic finish_pg(input logic [PW-1:0] pg);
    done_valid = 1'b1;
    done_page = pg;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic align();
    while (cyc % WL != 0) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 ready after reset", req_ready, 1);
    chk("R12 no lane after reset", dn_valid, 0);
  endtask

  task automatic t_merge();
    align();
    send(20'h000A1, 0, 0, 4'd1, 6'd1);
    send(20'h000A1, 0, 0, 4'd2, 6'd1);
    send(20'h000A1, 0, 0, 4'd3, 6'd1);
    chk("R2 one group", dn_valid, 2'b01);
    chk("R2 page", lpg(0), 20'h000A1);
    chk("R1 members same window", lmem(0), 3);
    chk("R9 count", lcnt(0), 3);
    chk("R9 tag0", ltag(0,0), 1);
    chk("R9 tag2", ltag(0,2), 3);
    take(2'b01);
    chk("R8 taken lane leaves", dn_valid, 0);
    finish_pg(20'h000A1);
  endtask

  task automatic t_mode();
    align();
    send(20'h000B2, 0, 0, 4'd1, 6'd1);
    send(20'h000B2, 1, 0, 4'd2, 6'd1);
    chk("R3 read offered alone", dn_valid, 2'b01);
    chk("R3 read mode", dn_write[0], 0);
    chk("R3 read members", lmem(0), 1);
    take(2'b01);
    chk("R6 write blocked by pending page", dn_valid, 0);
    finish_pg(20'h000B2);
    chk("R6 write offered after done", dn_valid, 2'b01);
    chk("R3 write mode", dn_write[0], 1);
    chk("R3 write leader", ltag(0,0), 2);
    take(2'b01);
    finish_pg(20'h000B2);
  endtask

  task automatic t_window();
    while (cyc % WL != WL-1) @(negedge clk);
    send(20'h000C3, 0, 0, 4'd5, 6'd1);
    send(20'h000C3, 0, 0, 4'd6, 6'd1);
    chk("R1 split at boundary", lmem(0), 1);
    chk("R1 first leader", ltag(0,0), 5);
    take(2'b01);
    finish_pg(20'h000C3);
    chk("R1 second group", dn_valid, 2'b01);
    chk("R1 second leader", ltag(0,0), 6);
    chk("R1 second members", lmem(0), 1);
    take(2'b01);
    finish_pg(20'h000C3);
  endtask

  task automatic t_disable();
    coalesce_off = 1'b1;
    align();
    send(20'h000D4, 0, 0, 4'd1, 6'd1);
    send(20'h000D4, 0, 0, 4'd2, 6'd1);
    coalesce_off = 1'b0;
    chk("R4 first alone", lmem(0), 1);
    take(2'b01);
    finish_pg(20'h000D4);
    chk("R4 second alone", lmem(0), 1);
    chk("R4 second leader", ltag(0,0), 2);
    take(2'b01);
    finish_pg(20'h000D4);
  endtask

  task automatic t_limit();
    align();
    send(20'h00011, 0, 0, 4'd1, 6'd1);
    send(20'h00022, 0, 0, 4'd2, 6'd1);
    send(20'h00033, 0, 0, 4'd3, 6'd1);
    chk("R5 two lanes", dn_valid, 2'b11);
    chk("R5 lane0 page", lpg(0), 20'h00011);
    chk("R5 lane1 page", lpg(1), 20'h00022);
    take(2'b10);
    chk("R8 refused lane0 keeps both", dn_valid, 2'b11);
    chk("R8 lane1 not taken alone", lpg(1), 20'h00022);
    take(2'b11);
    chk("R5 third follows", dn_valid, 2'b01);
    chk("R5 third page", lpg(0), 20'h00033);
    take(2'b01);
    finish_pg(20'h00011);
    finish_pg(20'h00022);
    finish_pg(20'h00033);
  endtask

  task automatic t_order();
    send(20'h00050, 0, 0, 4'd1, 6'd1);
    take(2'b01);
    align();
    send(20'h00050, 0, 0, 4'd2, 6'd1);
    send(20'h00060, 0, 0, 4'd3, 6'd1);
    chk("R6 skip past pending", dn_valid, 2'b01);
    chk("R6 later group page", lpg(0), 20'h00060);
    take(2'b01);
    finish_pg(20'h00060);
    @(negedge clk);
    align();
    send(20'h00070, 0, 0, 4'd4, 6'd1);
    chk("R7 later window held back", dn_valid, 0);
    finish_pg(20'h00050);
    chk("R7 older window first", dn_valid, 2'b01);
    chk("R7 older page", lpg(0), 20'h00050);
    take(2'b01);
    chk("R7 later window next", lpg(0), 20'h00070);
    take(2'b01);
    finish_pg(20'h00050);
    finish_pg(20'h00070);
  endtask

  task automatic t_prefetch();
    align();
    send(20'h00080, 0, 0, 4'd1, 6'd2);
    send(20'h00080, 0, 1, 4'd2, 6'd5);
    send(20'h00080, 0, 0, 4'd3, 6'd3);
    send(20'h00090, 0, 1, 4'd4, 6'd4);
    chk("R9 prefetch adds nothing", lcnt(0), 5);
    chk("R9 members incl prefetch", lmem(0), 3);
    chk("R9 prefetch tag", ltag(0,1), 2);
    chk("R9 prefetch leader count", lcnt(1), 0);
    take(2'b11);
    finish_pg(20'h00080);
    finish_pg(20'h00090);
  endtask

  task automatic t_full();
    coalesce_off = 1'b1;
    for (int i = 0; i < NS; i++) send(20'h000F0, 0, 0, IW'(i), 6'd1);
    coalesce_off = 1'b0;
    chk("R10 ready low when full", req_ready, 0);
    for (int i = 0; i < NS; i++) begin
      chk("R10 drain one at a time", dn_valid, 2'b01);
      take(2'b01);
      finish_pg(20'h000F0);
    end
    chk("R10 ready back", req_ready, 1);
  endtask

  task automatic t_capacity();
    align();
    for (int i = 1; i <= MM+1; i++) send(20'h000E0, 0, 0, IW'(i), 6'd1);
    chk("R11 first group full", lmem(0), MM);
    chk("R11 last tag of first", ltag(0,MM-1), MM);
    take(2'b01);
    finish_pg(20'h000E0);
    chk("R11 overflow group", lmem(0), 1);
    chk("R11 overflow leader", ltag(0,0), MM+1);
    take(2'b01);
    finish_pg(20'h000E0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_merge();
    t_mode();
    t_window();
    t_disable();
    t_limit();
    t_order();
    t_prefetch();
    t_full();
    t_capacity();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule